// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequencer

This block runs serial flash transactions from a small table of instruction words that software writes. No command is fixed in logic. Each sequence is a short program of up to eight instruction slots. A slot can send an opcode, send an address, idle the clock for dummy cycles, receive bytes or send bytes. Each slot chooses to use one, two or four data lines. Because of this, a single engine can serve flash parts whose opcodes, widths and dummy counts differ from one part to the next.

Software starts a sequence in one of two ways. A register-style trigger supplies a sequence index, a byte length and an address. A memory-mapped read trigger supplies only an address and uses a default sequence index that was programmed earlier. A lock guards the table: writes land only while it is unlocked. A write attempted while it is locked is dropped and sets a sticky error flag. The serial clock runs at half the system clock. Received bytes leave as single-cycle strobes, and each transmit byte is taken with a pop pulse.

Top module: `flash_seq_engine`

## Requirements
- R1: The table holds 64 words of 32 bits, and sequence s uses words 4s to 4s+3. Each word carries two 16-bit slots, and the lower half runs before the upper half. A slot is laid out as code[15:10], pad[9:8], operand[7:0].
- R2: After reset the table is locked and `tbl_err` is 0. A table write while locked changes nothing and sets `tbl_err`, which stays set until reset. `tbl_unlock` clears the lock and `tbl_lock` sets it.
- R3: Code 1 (command) shifts out its 8-bit operand MSB first.
- R4: The pad value selects the lines used: 0 uses io[0] out and io[1] in, 1 uses io[1:0], and 2 or 3 use io[3:0]. `io_oe` is high only on the lines of a command, address or write phase.
- R5: Code 2 (address) sends the 32-bit trigger address when its operand is 32. For any other operand it sends the low 24 address bits.
- R6: Code 3 (dummy) gives as many serial clock cycles as its operand, with every `io_oe` bit low.
- R7: Code 4 (read) receives the number of bytes in its operand, or the trigger length when the operand is 0. Each byte is assembled MSB first and presented on `rx_data` with a one-cycle `rx_valid`.
- R8: Code 5 (write) sends the same byte count as a read, taking each byte from `tx_data` with a one-cycle `tx_pop`.
- R9: A sequence ends at code 0, at an unknown code, or after its eighth slot. On the same cycle `cs_n` returns high, `done` pulses for one cycle and `busy` is low.
- R10: `busy` is high from the cycle after a trigger until the end of the sequence. Triggers that arrive while busy are ignored.
- R11: `mm_start` runs the sequence chosen by the last `dflt_we` write, using `mm_addr` as the address and a trigger length of 0.
- R12: `sck` is low while `cs_n` is high. Output data changes only while `sck` is low, and input data is sampled on the rising edge of `sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table word index |
| tbl_wdata | input | 32 | Table word data |
| tbl_unlock | input | 1 | Unlock table |
| tbl_lock | input | 1 | Lock table |
| tbl_err | output | 1 | Sticky locked-write error |
| dflt_we | input | 1 | Load default sequence index |
| dflt_idx | input | 4 | Default sequence index |
| cmd_start | input | 1 | Register-style trigger |
| cmd_seq | input | 4 | Sequence index for trigger |
| cmd_len | input | 8 | Trigger byte length |
| cmd_addr | input | 32 | Trigger address |
| mm_start | input | 1 | Memory-mapped read trigger |
| mm_addr | input | 32 | Memory-mapped read address |
| busy | output | 1 | Sequence running |
| done | output | 1 | End-of-sequence pulse |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| tx_data | input | 8 | Next byte to send |
| tx_pop | output | 1 | Transmit byte taken |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Serial data drive enables |
| io_in | input | 4 | Serial data in |

## Verification
`busy` goes high one system cycle after a trigger. `done`, the rise of `cs_n` and the fall of `busy` all arrive in the same later cycle. The bench therefore samples on the falling system clock: busy one cycle after the trigger edge, and the end condition from the counter that the done pulse advances. Serial results are counted in `sck` rising edges from the start of the sequence rather than in system cycles. The bench records the lines on every rising edge and feeds read data for edge n before that edge arrives, so the cycles spent between phases do not shift any expected bit. Received and popped bytes are counted on the falling clock edge after their strobe.

// File: rtl/flash_seq_engine.sv
module flash_seq_engine #(
  parameter int NSEQ  = 16,
  parameter int LEN_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tbl_we,
  input  logic [$clog2(NSEQ*4)-1:0] tbl_addr,
  input  logic [31:0]               tbl_wdata,
  input  logic                      tbl_unlock,
  input  logic                      tbl_lock,
  output logic                      tbl_err,
  input  logic                      dflt_we,
  input  logic [$clog2(NSEQ)-1:0]   dflt_idx,
  input  logic                      cmd_start,
  input  logic [$clog2(NSEQ)-1:0]   cmd_seq,
  input  logic [LEN_W-1:0]          cmd_len,
  input  logic [31:0]               cmd_addr,
  input  logic                      mm_start,
  input  logic [31:0]               mm_addr,
  output logic                      busy,
  output logic                      done,
  output logic                      rx_valid,
  output logic [7:0]                rx_data,
  input  logic [7:0]                tx_data,
  output logic                      tx_pop,
  output logic                      sck,
  output logic                      cs_n,
  output logic [3:0]                io_out,
  output logic [3:0]                io_oe,
  input  logic [3:0]                io_in
);
  localparam int WORDS = NSEQ * 4;
  localparam int SQW   = $clog2(NSEQ);
  localparam logic [5:0] C_CMD = 6'd1, C_ADDR = 6'd2, C_DUMMY = 6'd3,
                         C_READ = 6'd4, C_WRITE = 6'd5;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_FIN} st_t;

  st_t              st;
  logic [31:0]      tbl [WORDS];
  logic             locked;
  logic [SQW-1:0]   dflt_q, seq_q;
  logic [2:0]       slot_q;
  logic [31:0]      addr_q, sh_q;
  logic [LEN_W-1:0] len_q, bcnt_q;
  logic [7:0]       cnt_q, rx_sh;
  logic [1:0]       lg_q;
  logic [5:0]       kind_q;

  function automatic logic [3:0] lmask(input logic [1:0] l);
    return (l == 2'd0) ? 4'b0001 : (l == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  wire [31:0]      word   = tbl[{seq_q, slot_q[2:1]}];
  wire [15:0]      slot_w = slot_q[0] ? word[31:16] : word[15:0];
  wire [5:0]       code   = slot_w[15:10];
  wire [1:0]       lg     = (slot_w[9:8] == 2'd3) ? 2'd2 : slot_w[9:8];
  wire [7:0]       opnd   = slot_w[7:0];
  wire [7:0]       per_b  = 8'd8 >> lg;
  wire [LEN_W-1:0] nbytes = (opnd != 8'd0) ? LEN_W'(opnd) : len_q;
  wire [7:0]       rx_nx  = (lg_q == 2'd0) ? {rx_sh[6:0], io_in[1]} :
                            (lg_q == 2'd1) ? {rx_sh[5:0], io_in[1:0]} :
                                             {rx_sh[3:0], io_in};
  wire [31:0]      sh_nx  = (lg_q == 2'd0) ? (sh_q << 1) :
                            (lg_q == 2'd1) ? (sh_q << 2) : (sh_q << 4);

  assign busy   = (st != S_IDLE);
  assign io_out = (lg_q == 2'd0) ? {3'b000, sh_q[31]} :
                  (lg_q == 2'd1) ? {2'b00, sh_q[31:30]} : sh_q[31:28];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
      locked  <= 1'b1;
      tbl_err <= 1'b0;
      dflt_q  <= '0;
    end else begin
      if (tbl_we && !locked) tbl[tbl_addr] <= tbl_wdata;
      if (tbl_we && locked)  tbl_err <= 1'b1;
      if (tbl_lock)          locked <= 1'b1;
      else if (tbl_unlock)   locked <= 1'b0;
      if (dflt_we)           dflt_q <= dflt_idx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; seq_q <= '0; slot_q <= '0; addr_q <= '0; sh_q <= '0;
      len_q <= '0; bcnt_q <= '0; cnt_q <= '0; rx_sh <= '0; lg_q <= '0;
      kind_q <= '0; sck <= 1'b0; cs_n <= 1'b1; done <= 1'b0; io_oe <= '0;
      rx_valid <= 1'b0; rx_data <= '0; tx_pop <= 1'b0;
    end else begin
      done <= 1'b0; rx_valid <= 1'b0; tx_pop <= 1'b0;
      case (st)
        S_IDLE:
          if (cmd_start || mm_start) begin
            seq_q  <= cmd_start ? cmd_seq : dflt_q;
            len_q  <= cmd_start ? cmd_len : '0;
            addr_q <= cmd_start ? cmd_addr : mm_addr;
            slot_q <= '0;
            cs_n   <= 1'b0;
            st     <= S_FETCH;
          end
        S_FETCH: begin
          kind_q <= code;
          lg_q   <= lg;
          st     <= S_RUN;
          case (code)
            C_CMD: begin
              sh_q <= {opnd, 24'h0}; cnt_q <= per_b - 8'd1; io_oe <= lmask(lg);
            end
            C_ADDR: begin
              sh_q  <= (opnd == 8'd32) ? addr_q : {addr_q[23:0], 8'h0};
              cnt_q <= ((opnd == 8'd32) ? (8'd32 >> lg) : (8'd24 >> lg)) - 8'd1;
              io_oe <= lmask(lg);
            end
            C_DUMMY, C_READ, C_WRITE: begin
              io_oe  <= (code == C_WRITE) ? lmask(lg) : 4'b0000;
              cnt_q  <= (code == C_DUMMY) ? opnd - 8'd1 : per_b - 8'd1;
              bcnt_q <= nbytes;
              if (code == C_WRITE) begin
                sh_q <= {tx_data, 24'h0}; tx_pop <= (nbytes != '0);
              end
              if ((code == C_DUMMY) ? (opnd == 8'd0) : (nbytes == '0)) begin
                st <= (slot_q == 3'd7) ? S_FIN : S_FETCH;
                slot_q <= slot_q + 3'd1;
                tx_pop <= 1'b0;
              end
            end
            default: st <= S_FIN;
          endcase
        end
        S_RUN:
          if (!sck) begin
            sck <= 1'b1;
            if (kind_q == C_READ) rx_sh <= rx_nx;
          end else begin
            sck <= 1'b0;
            if (cnt_q != 8'd0) begin
              cnt_q <= cnt_q - 8'd1;
              sh_q  <= sh_nx;
            end else begin
              if (kind_q == C_READ) begin
                rx_valid <= 1'b1; rx_data <= rx_sh;
              end
              if ((kind_q == C_READ || kind_q == C_WRITE) && bcnt_q > LEN_W'(1)) begin
                bcnt_q <= bcnt_q - LEN_W'(1);
                cnt_q  <= (8'd8 >> lg_q) - 8'd1;
                if (kind_q == C_WRITE) begin
                  sh_q <= {tx_data, 24'h0}; tx_pop <= 1'b1;
                end
              end else begin
                io_oe  <= 4'b0000;
                st     <= (slot_q == 3'd7) ? S_FIN : S_FETCH;
                slot_q <= slot_q + 3'd1;
              end
            end
          end
        S_FIN: begin
          cs_n <= 1'b1; done <= 1'b1; io_oe <= 4'b0000; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  assert_locked_write_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && tbl_we) |=> tbl_err);
  assert_done_releases_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_trigger_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_start || mm_start)) |=> (seq_q == $past(seq_q)));
  assert_sck_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_drive_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'b0000) |-> !cs_n);
  assert_rx_inside_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);
endmodule

// File: tb/test_flash_seq_engine.sv
module test_flash_seq_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 0, tbl_unlock = 0, tbl_lock = 0, dflt_we = 0, cmd_start = 0, mm_start = 0;
  logic [5:0] tbl_addr = 0;
  logic [31:0] tbl_wdata = 0, cmd_addr = 0, mm_addr = 0;
  logic [3:0] dflt_idx = 0, cmd_seq = 0;
  logic [7:0] cmd_len = 0, tx_data, rx_data;
  logic tbl_err, busy, done, rx_valid, tx_pop, sck, cs_n;
  logic [3:0] io_out, io_oe, io_in;

  int nchk = 0, nfail = 0;
  int sck_total = 0, base = 0, rxn = 0, txn = 0, done_n = 0, tim_err = 0;
  int rd_start = 1000, rd_w = 1;
  logic [63:0] rd_pat = '0;
  logic [3:0] eo [128], eoe [128], last_io = '0;
  logic [7:0] rxb [64], txb [64];

  always #4 clk = ~clk;

  flash_seq_engine i_flash_seq_engine (.*);

  function automatic logic [3:0] rd_val(int n, int s, int w, logic [63:0] p);
    int b;
    if (n < s || (n - s) * w > 60) return 4'h0;
    b = 63 - (n - s) * w;
    case (w)
      1: return {2'b00, p[b], 1'b0};
      2: return {2'b00, p[b -: 2]};
      default: return p[b -: 4];
    endcase
  endfunction

  assign io_in   = rd_val(sck_total - base, rd_start, rd_w, rd_pat);
  assign tx_data = txb[txn % 64];

  always @(posedge sck) begin
    if (sck_total - base < 128) begin
      eo[sck_total - base]  = io_out;
      eoe[sck_total - base] = io_oe;
    end
    last_io = io_out;
    sck_total++;
  end

  always @(negedge clk) begin
    if (rx_valid) begin rxb[rxn % 64] = rx_data; rxn++; end
    if (tx_pop) txn++;
    if (done) done_n++;
    if ((sck && io_out != last_io) || (cs_n && sck)) tim_err++;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [5:0] c, logic [1:0] p, logic [7:0] o);
    return {c, p, o};
  endfunction

  function automatic logic [31:0] grab(int s, int n, int w);
    logic [31:0] v;
    v = '0;
    for (int e = s; e < s + n; e++)
      case (w)
        1: v = {v[30:0], eo[e][0]};
        2: v = {v[29:0], eo[e][1:0]};
        default: v = {v[27:0], eo[e]};
      endcase
    return v;
  endfunction

  task automatic wr_tbl(int idx, logic [31:0] d);
    @(negedge clk) tbl_we = 1; tbl_addr = 6'(idx); tbl_wdata = d;
    @(negedge clk) tbl_we = 0;
  endtask

  task automatic prog_seq(int s, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
    @(negedge clk) tbl_unlock = 1;
    @(negedge clk) tbl_unlock = 0;
    wr_tbl(4*s, w0); wr_tbl(4*s+1, w1); wr_tbl(4*s+2, w2); wr_tbl(4*s+3, w3);
    @(negedge clk) tbl_lock = 1;
    @(negedge clk) tbl_lock = 0;
  endtask

  task automatic pulse_cmd(int s, int len, logic [31:0] a);
    @(negedge clk) cmd_start = 1; cmd_seq = 4'(s); cmd_len = 8'(len); cmd_addr = a;
    @(negedge clk) cmd_start = 0;
  endtask

  task automatic wait_done(int d0);
    for (int i = 0; i < 5000 && done_n == d0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2", "tbl_err after reset", tbl_err, 0);
    chk("R9", "busy after reset", busy, 0);
    chk("R12", "cs_n/sck after reset", {cs_n, sck}, 2'b10);
  endtask

  task automatic t_lock_and_wren;
    int d0;
    prog_seq(2, {16'h0, mk(1, 0, 8'h06)}, 0, 0, 0);
    wr_tbl(8, {16'h0, mk(1, 0, 8'hAA)});
    chk("R2", "err after locked write", tbl_err, 1);
    base = sck_total; d0 = done_n;
    pulse_cmd(2, 0, 0);
    chk("R10", "busy one cycle after trigger", busy, 1);
    wait_done(d0);
    chk("R2", "locked write ignored, opcode", grab(0, 8, 1), 32'h06);
    chk("R3", "command edge count", sck_total - base, 8);
    chk("R9", "done count / cs_n / busy", {32'(done_n - d0), cs_n, busy}, {32'd1, 1'b1, 1'b0});
    chk("R4", "single line oe", eoe[0], 4'b0001);
  endtask

  task automatic t_erase;
    int d0;
    prog_seq(3, {mk(2, 0, 24), mk(1, 0, 8'h20)}, 0, 0, 0);
    chk("R2", "err stays sticky", tbl_err, 1);
    base = sck_total; d0 = done_n;
    pulse_cmd(3, 0, 32'hFF123456);
    wait_done(d0);
    chk("R5", "24-bit address", grab(8, 24, 1), 32'h123456);
    chk("R5", "erase edges", sck_total - base, 32);
  endtask

  task automatic t_quad_read;
    int d0, r0;
    logic [3:0] acc;
    prog_seq(4, {mk(2, 2, 32), mk(1, 0, 8'hEB)}, {mk(4, 2, 0), mk(3, 2, 6)}, 0, 0);
    rd_start = 22; rd_w = 4; rd_pat = {24'h5AC396, 40'h0};
    base = sck_total; d0 = done_n; r0 = rxn;
    pulse_cmd(4, 3, 32'hA1B2C3D4);
    wait_done(d0);
    chk("R5", "32-bit address on four lines", grab(8, 8, 4), 32'hA1B2C3D4);
    chk("R4", "four-line oe", eoe[8], 4'b1111);
    acc = 0;
    for (int e = 16; e < 28; e++) acc |= eoe[e];
    chk("R6", "dummy and read not driven", acc, 0);
    chk("R7", "byte count from length", rxn - r0, 3);
    chk("R7", "read bytes", {rxb[r0%64], rxb[(r0+1)%64], rxb[(r0+2)%64]}, 24'h5AC396);
    chk("R6", "total edges with 6 dummy", sck_total - base, 28);
  endtask

  task automatic t_program;
    int d0, t0;
    prog_seq(5, {mk(2, 0, 24), mk(1, 0, 8'h32)}, {16'h0, mk(5, 1, 2)}, 0, 0);
    t0 = txn; txb[t0 % 64] = 8'h9C; txb[(t0+1) % 64] = 8'h3F;
    base = sck_total; d0 = done_n;
    pulse_cmd(5, 7, 32'h00012345);
    wait_done(d0);
    chk("R8", "write data on two lines", grab(32, 8, 2), 32'h9C3F);
    chk("R8", "tx pops", txn - t0, 2);
    chk("R4", "two-line oe", eoe[32], 4'b0011);
    chk("R8", "program edges", sck_total - base, 40);
  endtask

  task automatic t_status;
    int d0, r0;
    prog_seq(6, {mk(4, 0, 1), mk(1, 0, 8'h05)}, 0, 0, 0);
    rd_start = 8; rd_w = 1; rd_pat = {8'hB7, 56'h0};
    base = sck_total; d0 = done_n; r0 = rxn;
    pulse_cmd(6, 9, 0);
    wait_done(d0);
    chk("R7", "operand count over length", rxn - r0, 1);
    chk("R4", "single-line read on io[1]", rxb[r0 % 64], 8'hB7);
    chk("R4", "read phase undriven", eoe[8], 0);
  endtask

  task automatic t_busy;
    int d0;
    base = sck_total; d0 = done_n;
    pulse_cmd(3, 0, 32'h00000ABC);
    repeat (10) @(negedge clk);
    pulse_cmd(2, 0, 0);
    wait_done(d0);
    repeat (100) @(negedge clk);
    chk("R10", "one sequence ran", done_n - d0, 1);
    chk("R10", "first opcode kept", grab(0, 8, 1), 32'h20);
    chk("R10", "edges of first sequence", sck_total - base, 32);
  endtask

  task automatic t_mm;
    int d0, r0;
    prog_seq(7, {mk(2, 0, 24), mk(1, 0, 8'h0B)}, {mk(4, 0, 2), mk(3, 0, 8)}, 0, 0);
    @(negedge clk) dflt_we = 1; dflt_idx = 7;
    @(negedge clk) dflt_we = 0;
    rd_start = 40; rd_w = 1; rd_pat = {16'h3CE1, 48'h0};
    base = sck_total; d0 = done_n; r0 = rxn;
    @(negedge clk) mm_start = 1; mm_addr = 32'h00ABCDEF;
    @(negedge clk) mm_start = 0;
    wait_done(d0);
    chk("R11", "default opcode", grab(0, 8, 1), 32'h0B);
    chk("R11", "mapped address", grab(8, 24, 1), 32'hABCDEF);
    chk("R11", "mapped read data", {rxb[r0%64], rxb[(r0+1)%64]}, 16'h3CE1);
  endtask

  task automatic t_eight_slots;
    int d0;
    prog_seq(8, {mk(1, 0, 2), mk(1, 0, 1)}, {mk(1, 0, 4), mk(1, 0, 3)},
                {mk(1, 0, 6), mk(1, 0, 5)}, {mk(1, 0, 8), mk(1, 0, 7)});
    prog_seq(9, {16'h0, mk(1, 0, 8'hFF)}, 0, 0, 0);
    base = sck_total; d0 = done_n;
    pulse_cmd(8, 0, 0);
    wait_done(d0);
    chk("R1", "slot order lower half first", grab(0, 32, 1), 32'h01020304);
    chk("R1", "slot order later words", grab(32, 32, 1), 32'h05060708);
    chk("R9", "stops after eighth slot", sck_total - base, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_lock_and_wren;
    t_erase;
    t_quad_read;
    t_program;
    t_status;
    t_busy;
    t_mm;
    t_eight_slots;
    chk("R12", "data change / idle clock violations", tim_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail + 1);
    $finish;
  end
endmodule